// File: doc/BRIEF.md
# Fetch-triggered CHR bank mapper

This block is a cartridge memory mapper for an 8-bit console. On the CPU side it decodes register writes in the upper ROM space and forms the PRG address. The lower 16 KB ROM window is switchable, and the upper 16 KB window always shows the last bank. A fixed 8 KB PRG RAM window sits below the ROM. The mapper also drives the nametable address bit that chooses between vertical and horizontal mirroring.

On the PPU side each 4 KB half of the pattern table has two CHR bank registers. A per-half selector flips between them on its own when the PPU fetches particular tile rows. The flip takes effect for the fetch after the one that triggered it. This lets the background switch tile sets part way across a scanline without CPU involvement.

Top module: `fetch_latch_mapper`

## Requirements
- R1: `prg_ram_ce` is high exactly for CPU addresses $6000-$7FFF and `prg_rom_ce` exactly for $8000-$FFFF; the two are never high together.
- R2: A write to $A000-$AFFF loads data bits 3:0 into the PRG bank; CPU $8000-$BFFF then reads `prg_addr` = {bank, cpu_addr[13:0]}.
- R3: CPU $C000-$FFFF always gives `prg_addr` = {4'hF, cpu_addr[13:0]}, whatever the PRG bank register holds.
- R4: Writes load data bits 4:0 into four CHR bank registers: $B000-$BFFF (low half, FD state), $C000-$CFFF (low half, FE state), $D000-$DFFF (high half, FD state), $E000-$EFFF (high half, FE state). `chr_addr` = {selected bank, ppu_addr[11:0]}.
- R5: A write to $F000-$FFFF sets mirroring from data bit 0. With 0 (vertical), `ciram_a10` follows ppu_addr[10]. With 1 (horizontal), it follows ppu_addr[11], and `mirror_h` shows the bit.
- R6: A PPU read (`ppu_rd` high) of $0FD8-$0FDF puts the low-half selector in the FD state, and a read of $0FE8-$0FEF puts it in the FE state. Reads of neighbouring addresses such as $0FD7, $0FE0 and $0FF8 leave it unchanged.
- R7: The same ranges offset by $1000 ($1FD8-$1FDF, $1FE8-$1FEF) control the high-half selector, independently of the low half.
- R8: The triggering fetch is served with the bank selected before the change; the new state applies from the next clock onward. Addresses presented with `ppu_rd` low never change a selector.
- R9: After reset both selectors are in the FE state, and the PRG bank, all CHR banks and mirroring are zero.
- R10: Writes to $6000-$9FFF, writes with `cpu_wr` low, and data bits above each register's width change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | One-cycle PPU read strobe |
| prg_addr | output | 18 | PRG ROM/RAM address |
| prg_rom_ce | output | 1 | PRG ROM select |
| prg_ram_ce | output | 1 | PRG RAM select |
| chr_addr | output | 17 | CHR ROM address |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |
| mirror_h | output | 1 | Current mirroring, 1 = horizontal |

## Verification
A wrong selector state does not show at the ports until the PPU next reads from that half. It then shows at once as the wrong upper bits of `chr_addr`, so every trigger is followed by a read in the same half. A one-cycle-early update would show on the triggering fetch itself, and the bench checks that fetch before the clock edge. A corrupted bank or mirroring register shows on the next CPU or PPU address that uses it, with no delay.

// File: rtl/fetch_latch_mapper.sv
module fetch_latch_mapper #(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [15:0]                cpu_addr,
  input  logic [7:0]                 cpu_data,
  input  logic                       cpu_wr,
  input  logic [13:0]                ppu_addr,
  input  logic                       ppu_rd,
  output logic [PRG_BANK_W+13:0]     prg_addr,
  output logic                       prg_rom_ce,
  output logic                       prg_ram_ce,
  output logic [CHR_BANK_W+11:0]     chr_addr,
  output logic                       ciram_a10,
  output logic                       mirror_h
);
  localparam int PRG_AW = PRG_BANK_W + 14;
  localparam int CHR_AW = CHR_BANK_W + 12;

  logic [PRG_BANK_W-1:0] prg_bank;
  logic [CHR_BANK_W-1:0] chr_bank [4];
  logic [1:0]            sel_fe;
  logic                  mir;

  logic       half, pat_fetch, row_fd, row_fe;
  logic [1:0] chr_idx;

  assign half      = ppu_addr[12];
  assign pat_fetch = ppu_rd && !ppu_addr[13];
  assign row_fd    = ppu_addr[11:3] == {8'hFD, 1'b1};
  assign row_fe    = ppu_addr[11:3] == {8'hFE, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_bank <= '0;
      mir      <= 1'b0;
      for (int i = 0; i < 4; i++) chr_bank[i] <= '0;
    end else if (cpu_wr) begin
      case (cpu_addr[15:12])
        4'hA: prg_bank    <= cpu_data[PRG_BANK_W-1:0];
        4'hB: chr_bank[0] <= cpu_data[CHR_BANK_W-1:0];
        4'hC: chr_bank[1] <= cpu_data[CHR_BANK_W-1:0];
        4'hD: chr_bank[2] <= cpu_data[CHR_BANK_W-1:0];
        4'hE: chr_bank[3] <= cpu_data[CHR_BANK_W-1:0];
        4'hF: mir         <= cpu_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_fe <= 2'b11;
    else if (pat_fetch && (row_fd || row_fe)) sel_fe[half] <= row_fe;
  end

  assign prg_rom_ce = cpu_addr[15];
  assign prg_ram_ce = cpu_addr[15:13] == 3'b011;
  assign prg_addr   = {cpu_addr[14] ? {PRG_BANK_W{1'b1}} : prg_bank, cpu_addr[13:0]};

  assign chr_idx    = {half, sel_fe[half]};
  assign chr_addr   = {chr_bank[chr_idx], ppu_addr[11:0]};

  assign mirror_h   = mir;
  assign ciram_a10  = mir ? ppu_addr[11] : ppu_addr[10];

  p_ce_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(prg_rom_ce && prg_ram_ce));

  p_fixed_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> (prg_addr[PRG_AW-1:14] == {PRG_BANK_W{1'b1}}));

  p_lo_fd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && ppu_addr[13:3] == {3'b000, 8'hFD, 1'b1}) |=>
      (ppu_addr[13:12] != 2'b00 || chr_addr[CHR_AW-1:12] == chr_bank[0]));

  p_hi_fe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && ppu_addr[13:3] == {3'b001, 8'hFE, 1'b1}) |=>
      (ppu_addr[13:12] != 2'b01 || chr_addr[CHR_AW-1:12] == chr_bank[3]));

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_rd |=> $stable(sel_fe));

  p_prg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr || cpu_addr[15:12] != 4'hA) |=> $stable(prg_bank));
endmodule

// File: tb/fetch_latch_mapper_bench.sv
module fetch_latch_mapper_bench;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_data = 0;
  logic        cpu_wr = 0, ppu_rd = 0;
  logic [13:0] ppu_addr = 0;
  logic [17:0] prg_addr;
  logic [16:0] chr_addr;
  logic        prg_rom_ce, prg_ram_ce, ciram_a10, mirror_h;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [3:0] m_prg;
  logic [4:0] m_chr [4];
  logic [1:0] m_fe;
  logic       m_mir;

  fetch_latch_mapper u_fetch_latch_mapper (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_chr(input logic [13:0] a);
    return {m_chr[{a[12], m_fe[a[12]]}], a[11:0]};
  endfunction

  function automatic logic [17:0] exp_prg(input logic [15:0] a);
    return {a[14] ? 4'hF : m_prg, a[13:0]};
  endfunction

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1;
    @(posedge clk); #1 cpu_wr = 0;
    case (a[15:12])
      4'hA: m_prg = d[3:0];
      4'hB: m_chr[0] = d[4:0];
      4'hC: m_chr[1] = d[4:0];
      4'hD: m_chr[2] = d[4:0];
      4'hE: m_chr[3] = d[4:0];
      4'hF: m_mir = d[0];
      default: ;
    endcase
  endtask

  task automatic cpu_look(input string req, input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; #1;
    chk(req, {31'd0, prg_ram_ce}, (a >= 16'h6000 && a <= 16'h7FFF));
    chk(req, {31'd0, prg_rom_ce}, {31'd0, a[15]});
    if (a[15]) chk(req, prg_addr, exp_prg(a));
  endtask

  task automatic ppu_read(input string req, input logic [13:0] a, input bit rd);
    @(negedge clk);
    ppu_addr = a; ppu_rd = rd; #1;
    chk(req, chr_addr, exp_chr(a));
    chk(req, {31'd0, ciram_a10}, m_mir ? a[11] : a[10]);
    @(posedge clk); #1 ppu_rd = 0;
    if (rd && !a[13]) begin
      if (a[11:0] >= 12'hFD8 && a[11:0] <= 12'hFDF) m_fe[a[12]] = 0;
      if (a[11:0] >= 12'hFE8 && a[11:0] <= 12'hFEF) m_fe[a[12]] = 1;
    end
  endtask

  task automatic t_reset;
    m_prg = 0; m_mir = 0; m_fe = 2'b11;
    for (int i = 0; i < 4; i++) m_chr[i] = 0;
    rst_n = 0; repeat (3) @(posedge clk); #1 rst_n = 1;
    cpu_look("R9 prg", 16'h8123);
    chk("R9 mirror", {31'd0, mirror_h}, 0);
    cpu_write(16'hB000, 8'h05); cpu_write(16'hD000, 8'h06);
    ppu_read("R9 latch0 FE", 14'h0000, 0);
    ppu_read("R9 latch1 FE", 14'h1000, 0);
  endtask

  task automatic t_prg;
    cpu_look("R1", 16'h6000); cpu_look("R1", 16'h7FFF); cpu_look("R1", 16'h5FFF);
    for (int b = 0; b < 16; b += 5) begin
      cpu_write(16'hA000 | 16'(b * 16'h55), 8'(b));
      cpu_look("R2", 16'h8000); cpu_look("R2", 16'hBFFF);
      cpu_look("R3", 16'hC000); cpu_look("R3", 16'hFFFF);
    end
  endtask

  task automatic t_chr_regs;
    cpu_write(16'hB7FF, 8'h03); cpu_write(16'hC123, 8'h11);
    cpu_write(16'hDABC, 8'h1C); cpu_write(16'hE000, 8'h1F);
    ppu_read("R4 lo FE", 14'h0ABC, 0);
    ppu_read("R4 hi FE", 14'h1ABC, 0);
  endtask

  task automatic t_mirror;
    cpu_write(16'hF000, 8'h01);
    chk("R5 mirror_h", {31'd0, mirror_h}, 1);
    ppu_read("R5 horiz", 14'h2800, 0); ppu_read("R5 horiz", 14'h2400, 0);
    cpu_write(16'hFFFF, 8'hFE);
    chk("R5 mirror_h", {31'd0, mirror_h}, 0);
    ppu_read("R5 vert", 14'h2800, 0); ppu_read("R5 vert", 14'h2400, 0);
  endtask

  task automatic t_latch(input logic half);
    logic [13:0] base;
    base = {1'b0, half, 12'h000};
    ppu_read("R6/R7 FD trigger", base | 14'h0FD8, 1);
    ppu_read("R8 new state", base | 14'h0100, 0);
    ppu_read("R6/R7 FE trigger", base | 14'h0FEF, 1);
    ppu_read("R8 new state", base | 14'h0100, 0);
    ppu_read("R6/R7 near", base | 14'h0FD7, 1);
    ppu_read("R6/R7 near", base | 14'h0FE0, 1);
    ppu_read("R6/R7 near", base | 14'h0FF8, 1);
    ppu_read("R6/R7 after near", base | 14'h0200, 0);
    ppu_read("R6/R7 FD end", base | 14'h0FDF, 1);
    ppu_read("R7 other half", {1'b0, ~half, 12'h300}, 0);
    ppu_read("R6/R7 held", base | 14'h0300, 0);
    ppu_read("R6/R7 FE start", base | 14'h0FE8, 1);
  endtask

  task automatic t_order;
    ppu_read("R8 trig", 14'h0FDC, 1);
    ppu_read("R8 next", 14'h0FDC, 1);
    ppu_read("R8 trig", 14'h1FEA, 1);
    ppu_read("R8 next", 14'h1FD9, 1);
    ppu_read("R8 next", 14'h1FD9, 1);
    ppu_read("R8 no rd", 14'h0FE9, 0);
    ppu_read("R8 no rd", 14'h0000, 0);
    ppu_read("R8 nametable", 14'h2FD8, 1);
    ppu_read("R8 nametable", 14'h0000, 0);
  endtask

  task automatic t_ignored;
    cpu_write(16'hA000, 8'hF3);
    cpu_look("R10 upper bits", 16'h8000);
    chk("R10 upper bits", prg_addr, {4'h3, 14'h0000});
    cpu_write(16'h9000, 8'h0A); cpu_write(16'h6000, 8'h0B); cpu_write(16'h8000, 8'h0C);
    @(negedge clk); cpu_addr = 16'hA000; cpu_data = 8'h09; cpu_wr = 0;
    @(posedge clk);
    cpu_look("R10 ignored", 16'h8000);
    chk("R10 ignored", prg_addr, {4'h3, 14'h0000});
    cpu_write(16'hB000, 8'hE7);
    ppu_read("R10 chr upper bits", 14'h0FE8, 1);
    ppu_read("R10 chr upper bits", 14'h0FD8, 1);
    chk("R10 chr upper bits", chr_addr[16:12], 5'h07);
  endtask

  initial begin
    t_reset();
    t_prg();
    t_chr_regs();
    t_mirror();
    t_latch(0);
    t_latch(1);
    t_order();
    t_ignored();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule